// File: doc/BRIEF.md
# Network Controller Interrupt Status Register

This block gathers single-cycle event pulses from the transmit MAC, the receive buffer manager and the bus interface of an Ethernet controller. It holds each event in a sticky status bit until software clears that bit by writing a 1 to its position. Two of the events are produced inside the block. A byte counter flags transmit frames that are too long. A watchdog flags a bus request that has gone without a grant for too long. A third helper keeps a count of frames that were dropped because no receive buffer was free.

The latched bits drive an active-low interrupt line. Each interrupting source is gated by its own mask bit and by one global enable. An error summary bit is the OR of the four error sources. It ignores both the enable and the masks. Collision error feeds the summary but never raises the interrupt. A receive-complete bit can optionally fire early, when the first descriptor of a packet is handed back.

Top module: `nic_irq_stat`

## Requirements
- R1: After hardware reset, `status` is 0x0000, `irq_n` is 1 and `miss_count` is 0. The status positions are: babble 14, collision error 13, missed frame 12, memory error 11, receive done 10, transmit done 9, init done 8, error summary 15. All other bits read 0.
- R2: Writing with `wr_en`=1 clears every status bit whose `wr_data` bit is 1. Bits written with 0 keep their value.
- R3: If a set event and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R4: While `stop` or `sw_rst` is 1, every status bit clears on the clock edge. `sw_rst` also clears `miss_count`.
- R5: `irq_n` is 0 exactly when `int_en` is 1 and at least one set bit among 14, 12, 11, 10, 9 and 8 has its `irq_mask` bit at the same position equal to 0.
- R6: Collision error (bit 13) never drives `irq_n` low.
- R7: `err_sum` and `status[15]` are 1 whenever bit 14, 13, 12 or 11 is set, whatever the values of `int_en` and `irq_mask`.
- R8: Babble (bit 14) sets on the clock edge that carries the 1519th byte of a transmit frame. A frame of 1518 bytes leaves it clear. The byte with `tx_last` ends the frame.
- R9: Memory error (bit 11) sets after `bus_req`=1 with `bus_gnt`=0 has been sampled for `tmo_limit`×`TICK_DIV` consecutive cycles. `tmo_limit` is counted in 0.1 µs units, so 512 gives 51.2 µs. A grant or a dropped request restarts the count. A limit of 0 disables the timeout.
- R10: Each `miss_evt` sets bit 12 and increments `miss_count`. The count saturates at all-ones.
- R11: `rx_last_rel` sets bit 10. `rx_first_rel` sets bit 10 only when `early_rx_en` is 1.
- R12: `tx_done_evt` sets bit 9 and `init_done_evt` sets bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| sw_rst | input | 1 | Synchronous soft reset |
| stop | input | 1 | Stop control; clears status |
| tx_byte | input | 1 | One transmit byte sent this cycle |
| tx_last | input | 1 | Current transmit byte ends the frame |
| cerr_evt | input | 1 | Collision error event |
| miss_evt | input | 1 | Missed receive frame event |
| rx_first_rel | input | 1 | First receive descriptor released |
| rx_last_rel | input | 1 | Last receive descriptor released |
| tx_done_evt | input | 1 | Last transmit descriptor released |
| init_done_evt | input | 1 | Initialization finished |
| early_rx_en | input | 1 | Allow early receive interrupt |
| bus_req | input | 1 | Bus request held by the controller |
| bus_gnt | input | 1 | Bus grant |
| tmo_limit | input | TMO_W | Bus timeout in 0.1 µs units |
| wr_en | input | 1 | Status write strobe |
| wr_data | input | 16 | Write-1-to-clear data |
| int_en | input | 1 | Global interrupt enable |
| irq_mask | input | 16 | Per-source mask, 1 blocks |
| status | output | 16 | Status word |
| err_sum | output | 1 | Error summary |
| irq_n | output | 1 | Interrupt, active low |
| miss_count | output | MISS_W | Missed frame count |

## Verification
A table of one-cycle patterns drives single events, masked events, a disabled enable, zero writes, partial clears and a clear that collides with a set. These patterns separate a correct write-1-to-clear from a plain write. They also separate the mask gating from the enable gating, and the collision-error exception from the summary logic. Directed runs send frames of 1518 and 1519 bytes to locate the babble boundary exactly. They hold a request for one cycle short of the timeout and for exactly the timeout, interrupt it with a grant, and set the limit to 0. They also drive the miss counter past its saturation point.

// File: rtl/nic_irq_pkg.sv
`timescale 1ns/1ps
package nic_irq_pkg;
   localparam int STAT_W = 16;
   localparam int B_ERR  = 15;
   localparam int B_BABL = 14;
   localparam int B_CERR = 13;
   localparam int B_MISS = 12;
   localparam int B_MERR = 11;
   localparam int B_RXD  = 10;
   localparam int B_TXD  = 9;
   localparam int B_INIT = 8;
   localparam logic [STAT_W-1:0] STICKY_MASK = 16'h7F00;
   localparam logic [STAT_W-1:0] IRQ_SRC     = 16'h5F00;
   localparam logic [STAT_W-1:0] ERR_SRC     = 16'h7800;
endpackage

// File: rtl/nic_babble_chk.sv
`timescale 1ns/1ps
module nic_babble_chk #(
   parameter int LIMIT = 1519
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sw_rst,
   input  logic byte_vld,
   input  logic byte_last,
   output logic babble_p
);
   localparam int CW = $clog2(LIMIT + 1);

   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("nic_babble_chk: LIMIT must be at least 2");
      end
   endgenerate

   logic [CW-1:0] seen_q;

   assign babble_p = byte_vld && (seen_q == CW'(LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         seen_q <= '0;
      else if (sw_rst)
         seen_q <= '0;
      else if (byte_vld) begin
         if (byte_last)
            seen_q <= '0;
         else if (seen_q != CW'(LIMIT))
            seen_q <= seen_q + 1'b1;
      end
   end

   // R8
   babble_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      babble_p && !byte_last |=> !babble_p);
endmodule

// File: rtl/nic_bus_wdog.sv
`timescale 1ns/1ps
module nic_bus_wdog #(
   parameter int TICK_DIV = 10,
   parameter int TMO_W    = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_rst,
   input  logic             req,
   input  logic             gnt,
   input  logic [TMO_W-1:0] limit,
   output logic             tmo_p
);
   generate
      if (TICK_DIV < 1) begin : g_bad_div
         $error("nic_bus_wdog: TICK_DIV must be positive");
      end
      if (TMO_W < 2) begin : g_bad_w
         $error("nic_bus_wdog: TMO_W too small");
      end
   endgenerate

   logic             waiting;
   logic             tick;
   logic [TMO_W-1:0] units_q;
   logic             fired_q;

   assign waiting = req && !gnt;

   generate
      if (TICK_DIV == 1) begin : g_no_pre
         assign tick = 1'b1;
      end else begin : g_pre
         localparam int PW = $clog2(TICK_DIV);
         logic [PW-1:0] pre_q;
         assign tick = (pre_q == PW'(TICK_DIV - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pre_q <= '0;
            else if (sw_rst || !waiting || tick)
               pre_q <= '0;
            else
               pre_q <= pre_q + 1'b1;
         end
      end
   endgenerate

   assign tmo_p = waiting && tick && !fired_q && (limit != '0) &&
                  (units_q == limit - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         units_q <= '0;
         fired_q <= 1'b0;
      end else if (sw_rst || !waiting) begin
         units_q <= '0;
         fired_q <= 1'b0;
      end else if (tick) begin
         if (units_q != '1)
            units_q <= units_q + 1'b1;
         if (tmo_p)
            fired_q <= 1'b1;
      end
   end

   // R9
   tmo_needs_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_p |-> req && !gnt);
   // R9
   tmo_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_p |=> !tmo_p);
endmodule

// File: rtl/nic_miss_ctr.sv
`timescale 1ns/1ps
module nic_miss_ctr #(
   parameter int W   = 16,
   parameter bit SAT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sw_rst,
   input  logic         inc,
   output logic [W-1:0] count
);
   generate
      if (W < 1) begin : g_bad_w
         $error("nic_miss_ctr: W must be positive");
      end
   endgenerate

   logic [W-1:0] cnt_q;
   logic [W-1:0] cnt_nx;

   generate
      if (SAT) begin : g_sat
         assign cnt_nx = (cnt_q == '1) ? cnt_q : cnt_q + 1'b1;
      end else begin : g_wrap
         assign cnt_nx = cnt_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (sw_rst)
         cnt_q <= '0;
      else if (inc)
         cnt_q <= cnt_nx;
   end

   assign count = cnt_q;

   // R10
   miss_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      SAT && cnt_q == '1 && inc && !sw_rst |=> cnt_q == '1);
   // R10
   miss_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inc && !sw_rst && cnt_q != '1 |=> cnt_q != '0);
endmodule

// File: rtl/nic_irq_stat.sv
`timescale 1ns/1ps
module nic_irq_stat
   import nic_irq_pkg::*;
#(
   parameter int BABBLE_LIMIT = 1519,
   parameter int TICK_DIV     = 10,
   parameter int TMO_W        = 16,
   parameter int MISS_W       = 16,
   parameter bit MISS_SAT     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_rst,
   input  logic              stop,
   input  logic              tx_byte,
   input  logic              tx_last,
   input  logic              cerr_evt,
   input  logic              miss_evt,
   input  logic              rx_first_rel,
   input  logic              rx_last_rel,
   input  logic              tx_done_evt,
   input  logic              init_done_evt,
   input  logic              early_rx_en,
   input  logic              bus_req,
   input  logic              bus_gnt,
   input  logic [TMO_W-1:0]  tmo_limit,
   input  logic              wr_en,
   input  logic [STAT_W-1:0] wr_data,
   input  logic              int_en,
   input  logic [STAT_W-1:0] irq_mask,
   output logic [STAT_W-1:0] status,
   output logic              err_sum,
   output logic              irq_n,
   output logic [MISS_W-1:0] miss_count
);
   logic              babl_p;
   logic              merr_p;
   logic [STAT_W-1:0] set_vec;
   logic [STAT_W-1:0] st_q;
   logic              wipe;

   assign wipe = sw_rst || stop;

   nic_babble_chk #(.LIMIT(BABBLE_LIMIT)) u_babble (
      .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst),
      .byte_vld(tx_byte), .byte_last(tx_last), .babble_p(babl_p)
   );

   nic_bus_wdog #(.TICK_DIV(TICK_DIV), .TMO_W(TMO_W)) u_wdog (
      .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst),
      .req(bus_req), .gnt(bus_gnt), .limit(tmo_limit), .tmo_p(merr_p)
   );

   nic_miss_ctr #(.W(MISS_W), .SAT(MISS_SAT)) u_miss (
      .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst),
      .inc(miss_evt), .count(miss_count)
   );

   always_comb begin
      set_vec         = '0;
      set_vec[B_BABL] = babl_p;
      set_vec[B_CERR] = cerr_evt;
      set_vec[B_MISS] = miss_evt;
      set_vec[B_MERR] = merr_p;
      set_vec[B_RXD]  = rx_last_rel || (early_rx_en && rx_first_rel);
      set_vec[B_TXD]  = tx_done_evt;
      set_vec[B_INIT] = init_done_evt;
   end

   for (genvar i = 0; i < STAT_W; i++) begin : g_bit
      if (STICKY_MASK[i]) begin : g_sticky
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               bit_q <= 1'b0;
            else if (wipe)
               bit_q <= 1'b0;
            else if (set_vec[i])
               bit_q <= 1'b1;
            else if (wr_en && wr_data[i])
               bit_q <= 1'b0;
         end
         assign st_q[i] = bit_q;
      end else begin : g_zero
         assign st_q[i] = 1'b0;
      end
   end

   assign err_sum = |(st_q & ERR_SRC);

   always_comb begin
      status        = st_q;
      status[B_ERR] = err_sum;
   end

   assign irq_n = !(int_en && |(st_q & IRQ_SRC & ~irq_mask));

   // R3
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done_evt && wr_en && wr_data[B_TXD] && !wipe |=> status[B_TXD]);
   // R4
   wipe_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wipe |=> status == '0);
   // R6
   cerr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status & ~16'h8000) == 16'h2000 |-> irq_n);
   // R5
   irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !int_en |-> irq_n);
   // R8
   babble_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      babl_p && !wipe |=> status[B_BABL] && err_sum);
   // R9
   merr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      merr_p && !wipe |=> status[B_MERR]);
endmodule

// File: tb/nic_irq_stat_test.sv
`timescale 1ns/1ps
module nic_irq_stat_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sw_rst = 0, stop = 0, tx_byte = 0, tx_last = 0;
   logic        cerr_evt = 0, miss_evt = 0, rx_first_rel = 0, rx_last_rel = 0;
   logic        tx_done_evt = 0, init_done_evt = 0, early_rx_en = 0;
   logic        bus_req = 0, bus_gnt = 0, wr_en = 0, int_en = 0;
   logic [15:0] tmo_limit = 16'd512;
   logic [15:0] wr_data = '0, irq_mask = '0;
   logic [15:0] status;
   logic        err_sum, irq_n;
   logic [3:0]  miss_count;

   int n_run = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   nic_irq_stat #(.MISS_W(4)) uut (
      .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .stop(stop),
      .tx_byte(tx_byte), .tx_last(tx_last), .cerr_evt(cerr_evt),
      .miss_evt(miss_evt), .rx_first_rel(rx_first_rel),
      .rx_last_rel(rx_last_rel), .tx_done_evt(tx_done_evt),
      .init_done_evt(init_done_evt), .early_rx_en(early_rx_en),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .tmo_limit(tmo_limit),
      .wr_en(wr_en), .wr_data(wr_data), .int_en(int_en),
      .irq_mask(irq_mask), .status(status), .err_sum(err_sum),
      .irq_n(irq_n), .miss_count(miss_count)
   );

   typedef struct packed {
      logic [5:0]  evt;   // 0 cerr,1 miss,2 rx_last,3 rx_first,4 tx_done,5 init
      logic        early;
      logic        wr;
      logic [15:0] wd;
      logic        en;
      logic [15:0] msk;
      logic [15:0] exp_st;
      logic        exp_irqn;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VEC [NV] = '{
      '{6'h01, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h0000, 16'hA000, 1'b1}, // R6 R7
      '{6'h10, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h0000, 16'hA200, 1'b0}, // R12 R5
      '{6'h00, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h0200, 16'hA200, 1'b1}, // R5 mask
      '{6'h00, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 16'hA200, 1'b1}, // R5 enable
      '{6'h00, 1'b0, 1'b1, 16'h0000, 1'b1, 16'h0000, 16'hA200, 1'b0}, // R2 zero write
      '{6'h00, 1'b0, 1'b1, 16'h2200, 1'b1, 16'h0000, 16'h0000, 1'b1}, // R2 R7
      '{6'h08, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h0000, 16'h0000, 1'b1}, // R11 no early
      '{6'h08, 1'b1, 1'b0, 16'h0000, 1'b1, 16'h0000, 16'h0400, 1'b0}, // R11 early
      '{6'h04, 1'b0, 1'b1, 16'h0400, 1'b1, 16'h0000, 16'h0400, 1'b0}, // R3 R11
      '{6'h00, 1'b0, 1'b1, 16'h0400, 1'b1, 16'h0000, 16'h0000, 1'b1}, // R2
      '{6'h02, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h0000, 16'h9000, 1'b0}, // R10 R7
      '{6'h20, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h1000, 16'h9100, 1'b0}, // R12 R5
      '{6'h00, 1'b0, 1'b1, 16'h1100, 1'b1, 16'h0000, 16'h0000, 1'b1}  // R2
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic idle_pulses();
      cerr_evt = 0; miss_evt = 0; rx_first_rel = 0; rx_last_rel = 0;
      tx_done_evt = 0; init_done_evt = 0; wr_en = 0; wr_data = '0;
      stop = 0; sw_rst = 0; tx_byte = 0; tx_last = 0;
   endtask

   task automatic wipe_all();
      @(negedge clk); wr_en = 1; wr_data = 16'hFFFF;
      @(negedge clk); idle_pulses();
   endtask

   task automatic send_frame(input int len);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         tx_byte = 1;
         tx_last = (i == len - 1);
      end
      @(negedge clk);
      tx_byte = 0; tx_last = 0;
   endtask

   initial begin
      #1_000_000;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check("R1 status", 32'(status), 32'h0);
      check("R1 irq_n", 32'(irq_n), 32'h1);
      check("R1 miss_count", 32'(miss_count), 32'h0);

      // table walk
      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         {tx_done_evt, rx_first_rel, rx_last_rel, miss_evt, cerr_evt} = VEC[v].evt[4:0];
         init_done_evt = VEC[v].evt[5];
         early_rx_en = VEC[v].early;
         wr_en = VEC[v].wr; wr_data = VEC[v].wd;
         int_en = VEC[v].en; irq_mask = VEC[v].msk;
         @(negedge clk);
         check($sformatf("R2/R5 table %0d status", v), 32'(status), 32'(VEC[v].exp_st));
         check($sformatf("R5 table %0d irq_n", v), 32'(irq_n), 32'(VEC[v].exp_irqn));
         check($sformatf("R7 table %0d err_sum", v), 32'(err_sum), 32'(VEC[v].exp_st[15]));
         idle_pulses();
         early_rx_en = 0;
      end
      int_en = 1; irq_mask = '0;
      // R10 count after one miss
      check("R10 count", 32'(miss_count), 32'h1);

      // R4 stop clears
      @(negedge clk); tx_done_evt = 1; cerr_evt = 1;
      @(negedge clk); idle_pulses(); stop = 1;
      @(negedge clk); stop = 0;
      check("R4 stop status", 32'(status), 32'h0);
      check("R4 stop miss kept", 32'(miss_count), 32'h1);
      // R4 sw_rst clears status and count
      @(negedge clk); init_done_evt = 1;
      @(negedge clk); idle_pulses(); sw_rst = 1;
      @(negedge clk); sw_rst = 0;
      check("R4 sw_rst status", 32'(status), 32'h0);
      check("R4 sw_rst count", 32'(miss_count), 32'h0);

      // R10 saturation
      for (int i = 0; i < 20; i++) begin
         @(negedge clk); miss_evt = 1;
      end
      @(negedge clk); miss_evt = 0;
      check("R10 saturate", 32'(miss_count), 32'hF);
      check("R10 bit", 32'(status), 32'h9000);
      wipe_all();

      // R8 babble boundary
      send_frame(1518);
      check("R8 1518 bytes", 32'(status), 32'h0);
      send_frame(1519);
      check("R8 1519 bytes", 32'(status), 32'hC000);
      check("R8 irq", 32'(irq_n), 32'h0);
      wipe_all();
      check("R2 clear all", 32'(status), 32'h0);

      // R9 timeout 3 units x 10 cycles
      tmo_limit = 16'd3;
      @(negedge clk); bus_req = 1;
      repeat (29) @(negedge clk);
      check("R9 one short", 32'(status[11]), 32'h0);
      @(negedge clk);
      check("R9 at limit", 32'(status), 32'h8800);
      bus_req = 0;
      wipe_all();
      // R9 grant restarts
      @(negedge clk); bus_req = 1;
      repeat (19) @(negedge clk);
      bus_gnt = 1;
      @(negedge clk); bus_gnt = 0;
      repeat (29) @(negedge clk);
      check("R9 grant reload", 32'(status[11]), 32'h0);
      @(negedge clk);
      check("R9 after reload", 32'(status[11]), 32'h1);
      bus_req = 0;
      wipe_all();
      // R9 limit 0 disables
      tmo_limit = 16'd0;
      @(negedge clk); bus_req = 1;
      repeat (60) @(negedge clk);
      check("R9 limit zero", 32'(status[11]), 32'h0);
      bus_req = 0;

      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end
endmodule